// File: doc/BRIEF.md
# Flash Erase-Block Select and Program/Erase Error Guard

This block sits in an embedded flash controller and holds the state that decides which flash block may be erased and whether programming and erasing are still allowed. It has two byte-wide erase-select registers. Together they cover sixteen blocks, and at most one bit across both can be set. It also has a status register whose top bit is a sticky error flag. The flag records that the processor misbehaved while a program or erase operation was in progress. While the flag is set, the protection output blocks any further program or erase activity.

Software reads and writes the registers over a small register bus. The rest of the chip drives the other inputs, which are level or one-cycle status signals:
- the program/erase mode indication,
- flash read strobes, with a qualifier that marks reads landing in RAM that overlays flash space,
- the start of exception handling, with its cause code,
- execution of a sleep instruction,
- the watchdog reset, the standby modes, the write-enable pin level and the software enable bit.

The asynchronous active-low reset is released synchronously inside the block, two clock edges after the pin goes high.

Top module: `flash_erase_guard`

## Requirements
- R1: The status register sits at address 0. Bit 7 returns the error flag and bits 6..0 always read 0. Bus writes to address 0 change neither the flag nor any output.
- R2: The error flag is 0 after reset. It is forced to 0 at the next edge by wdt_rst or hw_stby, and asynchronously by rst_n low. A clear wins over a set condition in the same cycle. Without a clear or a reset, a set flag stays set.
- R3: While pe_mode is 1, a flash read (fl_rd=1) sets the flag at the next edge unless rd_ram_ovl is 1. No input sets the flag while pe_mode is 0.
- R4: While pe_mode is 1, exc_start sets the flag at the next edge when exc_cause is 4 to 7. Causes 0 (reset), 1 (illegal instruction), 2 (trap) and 3 (divide by zero) do not set it.
- R5: While pe_mode is 1, sleep_exec sets the flag at the next edge. This covers the software standby entry.
- R6: prot_active equals the error flag at all times.
- R7: Address 1 holds blocks 7..0 and address 2 holds blocks 15..8, with bit i of a byte standing for block 8*(addr-1)+i. The blk_sel[15:0] output carries all sixteen. Both bytes reset to 0, and a write is seen on blk_sel and on reg_rdata after the next rising edge.
- R8: A write whose result would have more than one of the sixteen bits set instead clears all sixteen. blk_sel never has more than one bit set.
- R9: Both select bytes are cleared at the next edge when any of these holds: hw_stby=1, sw_stby=1, wen_pin=0, or wen_pin=1 with sw_pe_en=0. The clear takes priority over a write in the same cycle.
- R10: While flash_on is 0, addresses 1 and 2 read 0x00, and writes to them leave blk_sel unchanged.
- R11: Address 3 reads 0x00, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low pin/power-on reset |
| wdt_rst | input | 1 | Watchdog reset request, clears the error flag |
| hw_stby | input | 1 | Hardware standby active |
| sw_stby | input | 1 | Software standby active |
| wen_pin | input | 1 | Flash write-enable pin level |
| sw_pe_en | input | 1 | Software program/erase enable bit |
| flash_on | input | 1 | On-chip flash enabled |
| pe_mode | input | 1 | Program or erase operation in progress |
| fl_rd | input | 1 | Flash read access this cycle (data, vector or fetch) |
| rd_ram_ovl | input | 1 | The current read targets RAM overlaying flash |
| exc_start | input | 1 | Exception handling starts this cycle |
| exc_cause | input | 3 | Exception cause code (0 reset, 1 illegal, 2 trap, 3 divide, 4-7 others) |
| sleep_exec | input | 1 | Sleep instruction executes this cycle |
| reg_sel | input | 1 | Register bus access strobe |
| reg_wr | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| err_flag | output | 1 | Sticky program/erase error flag |
| prot_active | output | 1 | Program/erase protection active |
| blk_sel | output | 16 | Erase block select vector |

## Verification
Two things can land on the same edge. A register write to the select bytes can coincide with one of the clear conditions, and an error-setting event can coincide with a watchdog reset or hardware standby. The random phase drives rare clears independently of frequent writes and reads during program/erase, so both collisions recur many times. Directed cases force each collision once. The bench predicts the next state from the requirements, giving the clear precedence, and checks blk_sel, err_flag and the read data one edge later.

// File: rtl/fegd_pkg.sv
package fegd_pkg;

  localparam int CAUSE_W = 3;

  typedef enum logic [CAUSE_W-1:0] {
    EXC_RESET   = 3'd0,
    EXC_ILLEGAL = 3'd1,
    EXC_TRAP    = 3'd2,
    EXC_DIVZ    = 3'd3,
    EXC_IRQ     = 3'd4,
    EXC_NMI     = 3'd5,
    EXC_ADDR    = 3'd6,
    EXC_OTHER   = 3'd7
  } exc_cause_e;

  // Exceptions that mark a program/erase violation (R4)
  function automatic logic cause_flags(input exc_cause_e c);
    case (c)
      EXC_RESET, EXC_ILLEGAL, EXC_TRAP, EXC_DIVZ: cause_flags = 1'b0;
      default:                                    cause_flags = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/fegd_rst_sync.sv
module fegd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_core_n = chain_q[STAGES-1];

endmodule

// File: rtl/fegd_err_flag.sv
module fegd_err_flag
  import fegd_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_wdt,
  input  logic               clr_hstby,
  input  logic               pe_mode,
  input  logic               fl_rd,
  input  logic               rd_ram_ovl,
  input  logic               exc_start,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               sleep_exec,
  output logic               err_q
);

  logic hit_rd, hit_exc, hit_slp;
  logic set_hit, clr_hit;
  logic err_en, err_d;

  always_comb begin
    hit_rd  = pe_mode & fl_rd & ~rd_ram_ovl;
    hit_exc = pe_mode & exc_start & cause_flags(exc_cause_e'(exc_cause));
    hit_slp = pe_mode & sleep_exec;
    set_hit = hit_rd | hit_exc | hit_slp;
    clr_hit = clr_wdt | clr_hstby;
    err_en  = clr_hit | set_hit;
    err_d   = ~clr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      err_q <= 1'b0;
    else if (err_en) err_q <= err_d;
  end

  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_hit |=> !err_q); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q && !clr_hit) |=> err_q); // R2
  AST_ERR_RD_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_mode && fl_rd && !rd_ram_ovl && !clr_hit) |=> err_q); // R3
  AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!pe_mode && !err_q) |=> !err_q); // R3
  AST_ERR_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_mode && sleep_exec && !clr_hit) |=> err_q); // R5

endmodule

// File: rtl/fegd_erase_sel.sv
module fegd_erase_sel #(
  parameter int NUM_BANK = 2,
  parameter int BANK_W   = 8,
  parameter int ADDR_W   = 2,
  parameter int SEL_BASE = 1,
  localparam int NUM_BLK = NUM_BANK * BANK_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_any,
  input  logic              flash_on,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BANK_W-1:0] wr_data,
  output logic [NUM_BLK-1:0] sel_q
);

  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(SEL_BASE);
  localparam logic [ADDR_W-1:0] BANKS_A = ADDR_W'(NUM_BANK);

  logic [ADDR_W-1:0]  bank_off;
  logic               wr_hit;
  logic [NUM_BANK-1:0] bank_wr;
  logic [NUM_BLK-1:0] cand;
  logic               multi;
  logic               sel_en;
  logic [NUM_BLK-1:0] sel_d;

  always_comb begin
    bank_off = wr_addr - BASE_A;
    wr_hit   = wr_en & flash_on & (bank_off < BANKS_A);
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    assign bank_wr[b] = wr_hit & (bank_off == ADDR_W'(b));
    assign cand[b*BANK_W +: BANK_W] = bank_wr[b] ? wr_data
                                                 : sel_q[b*BANK_W +: BANK_W];
  end

  always_comb begin
    multi  = ($countones(cand) > 1);
    sel_en = clr_any | wr_hit;
    sel_d  = (clr_any | multi) ? '0 : cand;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q)); // R8
  AST_SEL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_any |=> (sel_q == '0)); // R9
  AST_SEL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && !clr_any) |=> $stable(sel_q)); // R10
  AST_SEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr_any) |=> $stable(sel_q)); // R7

endmodule

// File: rtl/flash_erase_guard.sv
module flash_erase_guard
  import fegd_pkg::*;
#(
  parameter int NUM_BANK  = 2,
  parameter int BANK_W    = 8,
  parameter int ADDR_W    = 2,
  parameter int STAT_ADDR = 0,
  parameter int SEL_BASE  = 1,
  parameter int FLAG_BIT  = 7,
  localparam int NUM_BLK  = NUM_BANK * BANK_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               hw_stby,
  input  logic               sw_stby,
  input  logic               wen_pin,
  input  logic               sw_pe_en,
  input  logic               flash_on,
  input  logic               pe_mode,
  input  logic               fl_rd,
  input  logic               rd_ram_ovl,
  input  logic               exc_start,
  input  logic [CAUSE_W-1:0] exc_cause,
  input  logic               sleep_exec,
  input  logic               reg_sel,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [BANK_W-1:0]  reg_wdata,
  output logic [BANK_W-1:0]  reg_rdata,
  output logic               err_flag,
  output logic               prot_active,
  output logic [NUM_BLK-1:0] blk_sel
);

  localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
  localparam logic [ADDR_W-1:0] BASE_A  = ADDR_W'(SEL_BASE);
  localparam logic [ADDR_W-1:0] BANKS_A = ADDR_W'(NUM_BANK);

  logic              rst_core_n;
  logic              err_q;
  logic              sel_clr;
  logic              bus_wr;
  logic [NUM_BLK-1:0] sel_q;
  logic [ADDR_W-1:0] rd_off;

  fegd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  fegd_err_flag u_err (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .clr_wdt    (wdt_rst),
    .clr_hstby  (hw_stby),
    .pe_mode    (pe_mode),
    .fl_rd      (fl_rd),
    .rd_ram_ovl (rd_ram_ovl),
    .exc_start  (exc_start),
    .exc_cause  (exc_cause),
    .sleep_exec (sleep_exec),
    .err_q      (err_q)
  );

  always_comb begin
    sel_clr = hw_stby | sw_stby | ~(wen_pin & sw_pe_en);
    bus_wr  = reg_sel & reg_wr;
  end

  fegd_erase_sel #(
    .NUM_BANK (NUM_BANK),
    .BANK_W   (BANK_W),
    .ADDR_W   (ADDR_W),
    .SEL_BASE (SEL_BASE)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .clr_any  (sel_clr),
    .flash_on (flash_on),
    .wr_en    (bus_wr),
    .wr_addr  (reg_addr),
    .wr_data  (reg_wdata),
    .sel_q    (sel_q)
  );

  always_comb begin
    rd_off    = reg_addr - BASE_A;
    reg_rdata = '0;
    if (reg_addr == STAT_A) begin
      reg_rdata[FLAG_BIT] = err_q;
    end else if (flash_on && (rd_off < BANKS_A)) begin
      for (int b = 0; b < NUM_BANK; b++) begin
        if (rd_off == ADDR_W'(b)) reg_rdata = sel_q[b*BANK_W +: BANK_W];
      end
    end
  end

  assign err_flag    = err_q;
  assign prot_active = err_q;
  assign blk_sel     = sel_q;

  AST_DIS_READ: assert property (@(posedge clk) disable iff (!rst_core_n)
    (!flash_on && (reg_addr != STAT_A)) |-> (reg_rdata == '0)); // R10
  AST_STAT_RSVD: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_addr == STAT_A) |-> (reg_rdata[FLAG_BIT] == err_flag)); // R1
  AST_EXC_SET: assert property (@(posedge clk) disable iff (!rst_core_n)
    (pe_mode && exc_start && (exc_cause >= 3'd4) && !wdt_rst && !hw_stby)
      |=> prot_active); // R4

endmodule

// File: tb/flash_erase_guard_test.sv
module flash_erase_guard_test;

  logic clk = 1'b0;
  logic rst_n, wdt_rst, hw_stby, sw_stby, wen_pin, sw_pe_en, flash_on;
  logic pe_mode, fl_rd, rd_ram_ovl, exc_start, sleep_exec;
  logic [2:0]  exc_cause;
  logic reg_sel, reg_wr;
  logic [1:0]  reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;
  logic err_flag, prot_active;
  logic [15:0] blk_sel;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic        m_err;
  logic [15:0] m_sel;

  always #5 clk = ~clk;

  flash_erase_guard uut (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .hw_stby(hw_stby),
    .sw_stby(sw_stby), .wen_pin(wen_pin), .sw_pe_en(sw_pe_en),
    .flash_on(flash_on), .pe_mode(pe_mode), .fl_rd(fl_rd),
    .rd_ram_ovl(rd_ram_ovl), .exc_start(exc_start), .exc_cause(exc_cause),
    .sleep_exec(sleep_exec), .reg_sel(reg_sel), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .err_flag(err_flag), .prot_active(prot_active), .blk_sel(blk_sel)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic err_next();
    logic set;
    set = pe_mode & ((fl_rd & ~rd_ram_ovl) | (exc_start & (exc_cause >= 3'd4)) | sleep_exec);
    if (wdt_rst | hw_stby) return 1'b0;
    return m_err | set;
  endfunction

  function automatic logic [15:0] sel_next();
    logic [15:0] c;
    if (hw_stby | sw_stby | ~wen_pin | ~sw_pe_en) return 16'h0;
    c = m_sel;
    if (reg_sel && reg_wr && flash_on) begin
      if (reg_addr == 2'd1) c[7:0]  = reg_wdata;
      if (reg_addr == 2'd2) c[15:8] = reg_wdata;
    end
    if ($countones(c) > 1) return 16'h0;
    return c;
  endfunction

  function automatic logic [7:0] rd_model();
    case (reg_addr)
      2'd0:    return {m_err, 7'h0};
      2'd1:    return flash_on ? m_sel[7:0]  : 8'h0;
      2'd2:    return flash_on ? m_sel[15:8] : 8'h0;
      default: return 8'h0;
    endcase
  endfunction

  task automatic idle_inputs();
    wdt_rst = 0; hw_stby = 0; sw_stby = 0; wen_pin = 1; sw_pe_en = 1; flash_on = 1;
    pe_mode = 0; fl_rd = 0; rd_ram_ovl = 0; exc_start = 0; exc_cause = 0; sleep_exec = 0;
    reg_sel = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
  endtask

  // Inputs are set at a negedge; this checks read data, clocks, checks state.
  task automatic step(input string tag);
    logic        ne;
    logic [15:0] ns;
    #1;
    case (reg_addr)
      2'd0:    chk({tag, " R1 status read"}, reg_rdata, rd_model());
      2'd3:    chk({tag, " R11 spare read"}, reg_rdata, rd_model());
      default: chk({tag, " R7 R10 select read"}, reg_rdata, rd_model());
    endcase
    ne = err_next();
    ns = sel_next();
    @(posedge clk);
    m_err = ne;
    m_sel = ns;
    @(negedge clk);
    chk({tag, " R2 R3 R4 R5 err_flag"}, err_flag, m_err);
    chk({tag, " R6 prot_active"}, prot_active, m_err);
    chk({tag, " R7 R8 R9 blk_sel"}, blk_sel, m_sel);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    reg_sel = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
  endtask

  task automatic do_reset();
    rst_n = 0;
    #1;
    m_err = 0; m_sel = 0;
    chk("R2 async reset err", err_flag, 1'b0);
    chk("R7 async reset sel", blk_sel, 16'h0);
    chk("R6 async reset prot", prot_active, 1'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    idle_inputs();
    repeat (3) step("post-reset idle");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED);
    idle_inputs();
    do_reset();

    // R7 single block in each byte
    @(negedge clk);
    wr(2'd1, 8'h04); step("R7 write low byte");
    idle_inputs(); reg_addr = 2'd1; step("R7 read low byte");
    wr(2'd2, 8'h00); step("R7 clear low? no, high byte zero keeps low");
    wr(2'd1, 8'h00); step("R7 clear low byte");
    wr(2'd2, 8'h80); step("R7 block 15");
    idle_inputs(); reg_addr = 2'd2; step("R7 read high byte");
    // R8 second bit in the other byte wipes both
    wr(2'd1, 8'h01); step("R8 cross-byte second bit");
    // R8 two bits in one write
    wr(2'd2, 8'h11); step("R8 two bits one write");
    wr(2'd1, 8'h20); step("R8 setup");
    // R9 clear wins over simultaneous write
    wr(2'd2, 8'h00); sw_stby = 1; step("R9 sw standby vs write");
    idle_inputs(); wr(2'd1, 8'h02); sw_pe_en = 0; step("R9 software enable low vs write");
    idle_inputs(); wr(2'd1, 8'h02); step("R9 setup");
    idle_inputs(); wen_pin = 0; step("R9 write-enable pin low");
    // R10 disabled flash
    idle_inputs(); wr(2'd2, 8'h08); step("R10 setup");
    idle_inputs(); flash_on = 0; wr(2'd1, 8'h01); step("R10 write ignored");
    idle_inputs(); flash_on = 0; reg_addr = 2'd2; step("R10 read zero");
    // R11 spare address
    idle_inputs(); wr(2'd3, 8'hFF); step("R11 spare write");
    // R1 status write has no effect
    idle_inputs(); wr(2'd0, 8'hFF); step("R1 status write ignored");
    // R3 overlap read does not set, outside-pe read does not set
    idle_inputs(); pe_mode = 1; fl_rd = 1; rd_ram_ovl = 1; step("R3 overlay RAM read");
    idle_inputs(); fl_rd = 1; sleep_exec = 1; exc_start = 1; exc_cause = 3'd6; step("R3 events outside pe");
    // R4 excluded causes
    for (int c = 0; c < 4; c++) begin
      idle_inputs(); pe_mode = 1; exc_start = 1; exc_cause = 3'(c); step("R4 excluded cause");
    end
    idle_inputs(); pe_mode = 1; exc_start = 1; exc_cause = 3'd5; step("R4 counted cause");
    idle_inputs(); reg_addr = 2'd0; step("R1 flag readback");
    // R2 clear wins over set
    idle_inputs(); pe_mode = 1; fl_rd = 1; wdt_rst = 1; step("R2 watchdog vs read");
    idle_inputs(); pe_mode = 1; sleep_exec = 1; step("R5 sleep during pe");
    idle_inputs(); pe_mode = 1; sleep_exec = 1; hw_stby = 1; step("R2 hw standby vs sleep");
    idle_inputs(); pe_mode = 1; fl_rd = 1; step("R3 read during pe");
    idle_inputs(); wr(2'd2, 8'h40); step("R2 flag holds");
    do_reset();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      idle_inputs();
      wdt_rst    = ($urandom % 64) == 0;
      hw_stby    = ($urandom % 64) == 0;
      sw_stby    = ($urandom % 64) == 0;
      wen_pin    = ($urandom % 32) != 0;
      sw_pe_en   = ($urandom % 32) != 0;
      flash_on   = ($urandom % 8) != 0;
      pe_mode    = ($urandom % 2) == 0;
      fl_rd      = ($urandom % 8) == 0;
      rd_ram_ovl = ($urandom % 2) == 0;
      exc_start  = ($urandom % 16) == 0;
      exc_cause  = 3'($urandom % 8);
      sleep_exec = ($urandom % 32) == 0;
      reg_sel    = ($urandom % 2) == 0;
      reg_wr     = ($urandom % 2) == 0;
      reg_addr   = 2'($urandom % 4);
      if (($urandom % 4) != 0) reg_wdata = (($urandom % 3) == 0) ? 8'h0 : 8'(1 << ($urandom % 8));
      else                     reg_wdata = 8'($urandom);
      step("random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule